// File: doc/BRIEF.md
# Paged Memory Mapper with Mirrored Page Registers

This block maps a 16-bit CPU address space onto a larger expansion RAM in 4 KiB pages. Sixteen 8-bit page registers, one for each 4 KiB region of the 64 KiB CPU space, supply the upper physical address bits. Software reaches them through a register window at CPU address 0x4000. Register n occupies the 16-bit word at byte offset 2n. Page values are written at the even byte, and a read of either byte of the word returns the register value.

Two single-bit control lines on a bit-addressed I/O bus gate the block. Writing bit 0 (I/O address 0x1E00) opens or closes the register window. Writing bit 1 (I/O address 0x1E02) switches translation on or off. With translation off, the page equals the CPU region number, which gives a flat 64 KiB view. Only the regions 0x2000–0x3FFF and 0xA000–0xFFFF select expansion RAM. The installed RAM is 256 KiB, so only the low six page bits reach the RAM, and larger page numbers wrap onto the same memory.

Top module: `page_mapper`

## Requirements
- R1: After reset, both control bits are clear, all page registers hold 0x00, and a read of the register window does not drive data (rdata_oe_o low, rdata_o zero).
- R2: An I/O write to address 0x1E00 loads io_bit_i into the window enable. An I/O write to 0x1E02 loads it into the translation enable. I/O writes to any other address change neither bit.
- R3: With the window enabled, a CPU write to byte address 0x4000+2n (n = 0..15) stores cpu_wdata_i in register n. A write to the odd byte 0x4000+2n+1 leaves the register unchanged.
- R4: With the window enabled, a CPU read of byte address 0x4000+2n or 0x4000+2n+1 returns register n on rdata_o, with rdata_oe_o high.
- R5: With the window disabled, window reads leave rdata_oe_o low and rdata_o zero, and window writes do not change any register.
- R6: With translation enabled, ram_addr_o equals bits 5..0 of register cpu_addr_i[15:12], followed by cpu_addr_i[11:0]. Page bits 7..6 are dropped, so page numbers wrap modulo 64.
- R7: With translation disabled, ram_addr_o equals {2'b00, cpu_addr_i}.
- R8: ram_cs_o is high exactly when cpu_rd_i or cpu_wr_i is high and cpu_addr_i lies in 0x2000–0x3FFF or 0xA000–0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | 16 | CPU byte address |
| cpu_wdata_i | input | 8 | CPU write data for page registers |
| cpu_rd_i | input | 1 | CPU read strobe |
| cpu_wr_i | input | 1 | CPU write strobe |
| io_addr_i | input | 16 | I/O bit address (bit k at base + 2k) |
| io_wr_i | input | 1 | I/O bit write strobe |
| io_bit_i | input | 1 | I/O bit write value |
| ram_addr_o | output | 18 | Translated expansion RAM byte address |
| ram_cs_o | output | 1 | Expansion RAM select |
| rdata_o | output | 8 | Page register read data |
| rdata_oe_o | output | 1 | Read data valid / drive enable |

## Verification
The assertions rely on the CPU read and write strobes being level signals that hold for whole clock cycles, with the address stable while a strobe is high. They also rely on the two control bits changing only through I/O write strobes. The stimulus changes every input only on the falling clock edge and holds it across the following rising edge. It never raises a CPU strobe and an I/O strobe in the same cycle, so each register update can be attributed to one access.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int unsigned CPU_AW    = 16;
  localparam int unsigned OFF_W     = 12;
  localparam int unsigned REGION_W  = CPU_AW - OFF_W;
  localparam int unsigned NUM_REGS  = 1 << REGION_W;
  localparam int unsigned IDX_W     = $clog2(NUM_REGS);
  localparam logic [REGION_W-1:0] LOW_RAM_FIRST  = 4'h2;
  localparam logic [REGION_W-1:0] LOW_RAM_LAST   = 4'h3;
  localparam logic [REGION_W-1:0] HIGH_RAM_FIRST = 4'hA;

  typedef logic [REGION_W-1:0] region_t;

  function automatic logic region_is_ram(input region_t r);
    return ((r >= LOW_RAM_FIRST) && (r <= LOW_RAM_LAST)) || (r >= HIGH_RAM_FIRST);
  endfunction
endpackage

// File: rtl/mapper_ctrl.sv
module mapper_ctrl #(
  parameter logic [15:0] CTRL_BASE = 16'h1E00
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] io_addr_i,
  input  logic        io_wr_i,
  input  logic        io_bit_i,
  output logic        win_en_o,
  output logic        map_en_o
);
  localparam logic [14:0] BIT0_ADDR = CTRL_BASE[15:1];
  localparam logic [14:0] BIT1_ADDR = CTRL_BASE[15:1] + 15'd1;

  // bit addressing: address bit 0 carries no bit-select information
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_en_o <= 1'b0;
      map_en_o <= 1'b0;
    end else if (io_wr_i) begin
      if (io_addr_i[15:1] == BIT0_ADDR) win_en_o <= io_bit_i;
      if (io_addr_i[15:1] == BIT1_ADDR) map_en_o <= io_bit_i;
    end
  end
endmodule

// File: rtl/mapper_regfile.sv
module mapper_regfile #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned PAGE_W   = 8,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [PAGE_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [PAGE_W-1:0] rd_data_o,
  input  logic [IDX_W-1:0]  xl_idx_i,
  output logic [PAGE_W-1:0] xl_data_o
);
  logic [PAGE_W-1:0] page_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) page_q[g] <= '0;
      else if (wr_en_i && (wr_idx_i == IDX_W'(g))) page_q[g] <= wr_data_i;
    end
  end

  // separate ports: software readback and address translation
  assign rd_data_o = page_q[rd_idx_i];
  assign xl_data_o = page_q[xl_idx_i];
endmodule

// File: rtl/mapper_xlate.sv
module mapper_xlate
  import mapper_pkg::*;
#(
  parameter int unsigned PAGE_W      = 8,
  parameter int unsigned PHYS_PAGE_W = 6,
  localparam int unsigned RAM_AW     = PHYS_PAGE_W + OFF_W
) (
  input  logic              map_en_i,
  input  logic [CPU_AW-1:0] cpu_addr_i,
  input  logic              cpu_rd_i,
  input  logic              cpu_wr_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic              ram_cs_o
);
  region_t           region;
  logic [PAGE_W-1:0] page_sel;

  assign region   = cpu_addr_i[CPU_AW-1:OFF_W];
  assign page_sel = map_en_i ? page_i : PAGE_W'(region);

  // truncation to the installed page count makes page numbers wrap
  assign ram_addr_o = {page_sel[PHYS_PAGE_W-1:0], cpu_addr_i[OFF_W-1:0]};
  assign ram_cs_o   = (cpu_rd_i || cpu_wr_i) && region_is_ram(region);
endmodule

// File: rtl/page_mapper.sv
module page_mapper
  import mapper_pkg::*;
#(
  parameter logic [15:0] CTRL_BASE   = 16'h1E00,
  parameter logic [15:0] WIN_BASE    = 16'h4000,
  parameter int unsigned PAGE_W      = 8,
  parameter int unsigned PHYS_PAGE_W = 6,
  localparam int unsigned RAM_AW     = PHYS_PAGE_W + OFF_W,
  localparam int unsigned WIN_LSB    = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       cpu_addr_i,
  input  logic [PAGE_W-1:0] cpu_wdata_i,
  input  logic              cpu_rd_i,
  input  logic              cpu_wr_i,
  input  logic [15:0]       io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_bit_i,
  output logic [RAM_AW-1:0] ram_addr_o,
  output logic              ram_cs_o,
  output logic [PAGE_W-1:0] rdata_o,
  output logic              rdata_oe_o
);
  logic              win_en_q, map_en_q;
  logic              win_hit, reg_wr;
  logic [IDX_W-1:0]  win_idx;
  logic [PAGE_W-1:0] rd_page, xl_page;

  mapper_ctrl #(.CTRL_BASE(CTRL_BASE)) u_ctrl (
    .clk_i, .rst_ni, .io_addr_i, .io_wr_i, .io_bit_i,
    .win_en_o(win_en_q), .map_en_o(map_en_q)
  );

  assign win_hit = (cpu_addr_i[CPU_AW-1:WIN_LSB] == WIN_BASE[CPU_AW-1:WIN_LSB]);
  assign win_idx = cpu_addr_i[IDX_W:1];
  // only the even byte of a register word is writable
  assign reg_wr  = win_en_q && win_hit && cpu_wr_i && !cpu_addr_i[0];

  mapper_regfile #(.NUM_REGS(NUM_REGS), .PAGE_W(PAGE_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(reg_wr), .wr_idx_i(win_idx), .wr_data_i(cpu_wdata_i),
    .rd_idx_i(win_idx), .rd_data_o(rd_page),
    .xl_idx_i(cpu_addr_i[CPU_AW-1:OFF_W]), .xl_data_o(xl_page)
  );

  // both bytes of a word mirror the register
  assign rdata_oe_o = win_en_q && win_hit && cpu_rd_i;
  assign rdata_o    = rdata_oe_o ? rd_page : '0;

  mapper_xlate #(.PAGE_W(PAGE_W), .PHYS_PAGE_W(PHYS_PAGE_W)) u_xlate (
    .map_en_i(map_en_q), .cpu_addr_i, .cpu_rd_i, .cpu_wr_i,
    .page_i(xl_page), .ram_addr_o, .ram_cs_o
  );
endmodule

// File: rtl/page_mapper_chk.sv
module page_mapper_chk #(
  parameter int unsigned RAM_AW = 18,
  parameter int unsigned PAGE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       cpu_addr_i,
  input logic              cpu_rd_i,
  input logic              cpu_wr_i,
  input logic              io_wr_i,
  input logic [RAM_AW-1:0] ram_addr_o,
  input logic              ram_cs_o,
  input logic [PAGE_W-1:0] rdata_o,
  input logic              rdata_oe_o,
  input logic              win_en_i,
  input logic              map_en_i
);
  logic in_ram;
  assign in_ram = (cpu_addr_i[15:13] == 3'b001) || (cpu_addr_i[15] && (cpu_addr_i[14] || cpu_addr_i[13]));

  assert_ctrl_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_wr_i |=> ($stable(win_en_i) && $stable(map_en_i)));

  assert_read_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_oe_o |-> (cpu_rd_i && cpu_addr_i[15:5] == 11'h200));

  assert_win_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_en_i |-> (!rdata_oe_o && rdata_o == '0));

  assert_offset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_cs_o |-> (ram_addr_o[11:0] == cpu_addr_i[11:0]));

  assert_flat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !map_en_i |-> (ram_addr_o == RAM_AW'(cpu_addr_i)));

  assert_cs_region_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_cs_o |-> ((cpu_rd_i || cpu_wr_i) && in_ram));

  assert_cs_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_cs_o && rdata_oe_o));
endmodule

bind page_mapper page_mapper_chk #(.RAM_AW(RAM_AW), .PAGE_W(PAGE_W)) u_chk (
  .clk_i, .rst_ni, .cpu_addr_i, .cpu_rd_i, .cpu_wr_i, .io_wr_i,
  .ram_addr_o, .ram_cs_o, .rdata_o, .rdata_oe_o,
  .win_en_i(win_en_q), .map_en_i(map_en_q)
);

// File: tb/tb_page_mapper.sv
`timescale 1ns/1ps
module tb_page_mapper;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cpu_addr_i = '0;
  logic [7:0]  cpu_wdata_i = '0;
  logic        cpu_rd_i = 1'b0, cpu_wr_i = 1'b0;
  logic [15:0] io_addr_i = '0;
  logic        io_wr_i = 1'b0, io_bit_i = 1'b0;
  logic [17:0] ram_addr_o;
  logic        ram_cs_o;
  logic [7:0]  rdata_o;
  logic        rdata_oe_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  page_mapper dut (.*);

  typedef struct packed {
    logic [15:0] a;
    logic        rd, wr, map, cs;
    logic [17:0] ra;
  } vec_t;

  // registers hold 0xF0|n, so the wrapped page is 0x30|n when mapped
  localparam vec_t VECS [11] = '{
    '{16'h2123, 1'b1, 1'b0, 1'b1, 1'b1, 18'h32123},
    '{16'h3FFF, 1'b0, 1'b1, 1'b1, 1'b1, 18'h33FFF},
    '{16'hA000, 1'b1, 1'b0, 1'b1, 1'b1, 18'h3A000},
    '{16'hFFFE, 1'b1, 1'b0, 1'b1, 1'b1, 18'h3FFFE},
    '{16'h5000, 1'b1, 1'b0, 1'b1, 1'b0, 18'h35000},
    '{16'h1FFF, 1'b1, 1'b0, 1'b1, 1'b0, 18'h31FFF},
    '{16'h9FFF, 1'b0, 1'b1, 1'b1, 1'b0, 18'h39FFF},
    '{16'h2000, 1'b0, 1'b0, 1'b1, 1'b0, 18'h32000},
    '{16'hC456, 1'b0, 1'b1, 1'b1, 1'b1, 18'h3C456},
    '{16'h2ABC, 1'b1, 1'b0, 1'b0, 1'b1, 18'h02ABC},
    '{16'hE001, 1'b1, 1'b0, 1'b0, 1'b1, 18'h0E001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic b);
    @(negedge clk_i);
    io_addr_i = a; io_bit_i = b; io_wr_i = 1'b1;
    @(negedge clk_i);
    io_wr_i = 1'b0;
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_wdata_i = d; cpu_wr_i = 1'b1; cpu_rd_i = 1'b0;
    @(negedge clk_i);
    cpu_wr_i = 1'b0;
  endtask

  task automatic probe(input logic [15:0] a, input logic rd, input logic wr);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_rd_i = rd; cpu_wr_i = wr;
    #1;
  endtask

  task automatic idle();
    @(negedge clk_i);
    cpu_rd_i = 1'b0; cpu_wr_i = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic cur_map;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: reset state
    probe(16'h4000, 1'b1, 1'b0);
    check("R1 oe", 32'(rdata_oe_o), 32'h0);
    check("R1 rdata", 32'(rdata_o), 32'h0);
    probe(16'h2345, 1'b1, 1'b0);
    check("R1 flat addr", 32'(ram_addr_o), 32'h02345);
    idle();
    io_write(16'h1E00, 1'b1);
    probe(16'h400A, 1'b1, 1'b0);
    check("R1 reg zero", 32'(rdata_o), 32'h0);
    check("R4 oe", 32'(rdata_oe_o), 32'h1);
    idle();

    // R3: fill registers
    for (int n = 0; n < 16; n++) cpu_write(16'h4000 + 16'(2*n), 8'hF0 | 8'(n));

    // R4: both bytes mirror
    for (int n = 0; n < 16; n += 7) begin
      probe(16'h4000 + 16'(2*n), 1'b1, 1'b0);
      check("R4 even", 32'(rdata_o), 32'(8'hF0 | 8'(n)));
      probe(16'h4001 + 16'(2*n), 1'b1, 1'b0);
      check("R4 odd", 32'(rdata_o), 32'(8'hF0 | 8'(n)));
    end
    idle();

    // R3: odd byte write ignored
    cpu_write(16'h4007, 8'h55);
    probe(16'h4006, 1'b1, 1'b0);
    check("R3 odd write", 32'(rdata_o), 32'hF3);
    idle();

    // R6/R7/R8 vector walk
    cur_map = 1'b0;
    foreach (VECS[i]) begin
      if (VECS[i].map != cur_map) begin
        idle();
        io_write(16'h1E02, VECS[i].map);
        cur_map = VECS[i].map;
      end
      probe(VECS[i].a, VECS[i].rd, VECS[i].wr);
      check(VECS[i].map ? "R6 addr" : "R7 addr", 32'(ram_addr_o), 32'(VECS[i].ra));
      check("R8 cs", 32'(ram_cs_o), 32'(VECS[i].cs));
    end
    idle();

    // R4 readback unaffected by translation
    io_write(16'h1E02, 1'b1);
    probe(16'h4003, 1'b1, 1'b0);
    check("R4 mapped readback", 32'(rdata_o), 32'hF1);
    check("R8 no cs in window", 32'(ram_cs_o), 32'h0);
    idle();

    // R2: other I/O address ignored
    io_write(16'h1E04, 1'b0);
    probe(16'hA000, 1'b1, 1'b0);
    check("R2 stray io", 32'(ram_addr_o), 32'h3A000);
    idle();

    // R5: closed window
    io_write(16'h1E00, 1'b0);
    probe(16'h4004, 1'b1, 1'b0);
    check("R5 oe", 32'(rdata_oe_o), 32'h0);
    check("R5 rdata", 32'(rdata_o), 32'h0);
    idle();
    cpu_write(16'h4004, 8'h11);
    io_write(16'h1E00, 1'b1);
    probe(16'h4004, 1'b1, 1'b0);
    check("R5 write ignored", 32'(rdata_o), 32'hF2);
    idle();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule